// File: doc/BRIEF.md
# Dual-Lane Serial Result Shifter

This block sends a set of eight 18-bit conversion results to a host over two serial data lines. A one-cycle load pulse captures all eight results into a snapshot and rewinds the read position to the most significant bit of channel 1. The host drives an active-low chip select and a serial clock. Both inputs arrive asynchronously and are sampled by the much faster system clock. When chip select falls, both lanes are driven and each shows the MSB of its current result. Each later serial clock rising edge moves both lanes one bit further.

Lane A reads channels 1 to 8 in order. Lane B reads the same eight results starting four channels later. A host that uses both lines needs 72 serial clocks to read all eight results. A host that uses lane A alone keeps clocking through all eight channels in 144 clocks. The read position carries over when chip select is released and asserted again, so the host may frame the whole read or each 18-clock channel. A first-data flag marks the start of channel 1 on lane A.

Top module: `dual_lane_shifter`

## Requirements
- R1: A falling edge of `csN` raises `driveEn`. Each lane then shows the MSB (bit 17) of the result at the current position. Channel k occupies bits [18k+17:18k] of `results`, with k = 0 for channel 1.
- R2: While `csN` is low, each rising edge of `sclk` moves both lanes one bit toward the LSB. Every result therefore takes 18 clocks. The 18th rising edge moves to the MSB of the next channel.
- R3: Lane A (`doutA`) carries channels in the order 1,2,...,8. Lane B (`doutB`) carries 5,6,7,8,1,2,3,4. Lane B always stays four channels ahead of lane A.
- R4: After channel 8 the position wraps to channel 1. A single-lane read therefore runs 144 clocks under one chip select and returns to channel 1.
- R5: A rising edge of `csN` lowers `driveEn` and keeps the read position. The next chip-select frame continues from that position.
- R6: `firstData` rises with the chip-select falling edge when lane A stands at bit 17 of channel 1. It falls after the 18th `sclk` falling edge.
- R7: `firstData` stays low for every other chip-select falling edge, including the one where channel 1 is on lane B. It also stays low when the position wraps to channel 1 without a new chip-select falling edge.
- R8: A `load` pulse captures `results` and sets the position to bit 17 of channel 1 on lane A and channel 5 on lane B. The result is visible on the lanes one system clock edge later.
- R9: `sclk` edges while `csN` is high do not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture results and rewind the read position |
| results | input | 144 | Eight 18-bit results, channel 1 in the low bits |
| csN | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| doutA | output | 1 | Lane A serial data |
| doutB | output | 1 | Lane B serial data |
| driveEn | output | 1 | Output enable for both lanes and the flag |
| firstData | output | 1 | First-data flag for channel 1 on lane A |

## Verification
A change on `csN` or `sclk` reaches the outputs on the third system clock edge after it is applied. Two of those edges are the synchronizer and the third updates the position, enable and flag. A `load` pulse takes effect on the next edge. The bench holds every serial clock phase and every chip-select level for four system clocks and samples at the falling system clock edge after the fourth. Each sample therefore lands after the update is settled and before the next stimulus arrives. Lane bits are checked after every rising serial clock edge. The flag is checked at each chip-select falling edge and after each 18th falling edge.

// File: rtl/serShiftPkg.sv
package serShiftPkg;
  localparam int NumCh     = 8;
  localparam int ResW      = 18;
  localparam int SyncDepth = 2;
  localparam int ChW       = $clog2(NumCh);
  localparam int BitW      = $clog2(ResW);
  localparam int HalfCh    = NumCh / 2;
  localparam int NumLanes  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic            capture;
    logic [ChW-1:0]  chA;
    logic [ChW-1:0]  chB;
    logic [BitW-1:0] bitPos;
  } shiftStrobes_t;
endpackage

// File: rtl/serShiftCtrl.sv
module serShiftCtrl
  import serShiftPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          csN,
  input  logic          sclk,
  output shiftStrobes_t strobes,
  output logic          driveEn,
  output logic          firstFlag
);
  localparam logic [BitW-1:0] LastBit = BitW'(ResW - 1);
  localparam logic [ChW-1:0]  LastCh  = ChW'(NumCh - 1);
  localparam logic [ChW-1:0]  HalfIdx = ChW'(HalfCh);

  logic [SyncDepth:0] csPipe, sclkPipe;
  logic syncCs, prevCs, syncSclk, prevSclk;
  logic csFallEv, csRiseEv, sclkRiseEv, sclkFallEv;
  logic [ChW-1:0]  chA, chB;
  logic [BitW-1:0] bitPos;

  // two-flop synchronizers plus one history stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
    end else begin
      csPipe   <= {csPipe[SyncDepth-1:0], csN};
      sclkPipe <= {sclkPipe[SyncDepth-1:0], sclk};
    end
  end

  assign syncCs     = csPipe[SyncDepth-1];
  assign prevCs     = csPipe[SyncDepth];
  assign syncSclk   = sclkPipe[SyncDepth-1];
  assign prevSclk   = sclkPipe[SyncDepth];
  assign csFallEv   = prevCs & ~syncCs;
  assign csRiseEv   = ~prevCs & syncCs;
  assign sclkRiseEv = syncSclk & ~prevSclk & ~syncCs;
  assign sclkFallEv = ~syncSclk & prevSclk & ~syncCs;

  function automatic logic [ChW-1:0] nextCh(input logic [ChW-1:0] c);
    return (c == LastCh) ? '0 : c + 1'b1;
  endfunction

  // read position
  always_ff @(posedge clk) begin
    if (!rstN || load) begin
      chA    <= '0;
      chB    <= HalfIdx;
      bitPos <= '0;
    end else if (sclkRiseEv) begin
      if (bitPos == LastBit) begin
        bitPos <= '0;
        chA    <= nextCh(chA);
        chB    <= nextCh(chB);
      end else begin
        bitPos <= bitPos + 1'b1;
      end
    end
  end

  // output enable and first-data flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      driveEn   <= 1'b0;
      firstFlag <= 1'b0;
    end else if (csFallEv) begin
      driveEn   <= 1'b1;
      firstFlag <= (chA == '0) && (bitPos == '0);
    end else if (csRiseEv) begin
      driveEn   <= 1'b0;
      firstFlag <= 1'b0;
    end else if (sclkFallEv && chA != '0) begin
      firstFlag <= 1'b0;
    end
  end

  assign strobes.capture = load;
  assign strobes.chA     = chA;
  assign strobes.chB     = chB;
  assign strobes.bitPos  = bitPos;

  // R3
  lane_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(chB) == (int'(chA) + HalfCh) % NumCh);
  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(bitPos) < ResW);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncCs && !load |=> $stable(bitPos) && $stable(chA));
  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    csRiseEv |=> !driveEn && !firstFlag);
  // R1
  engage_chk: assert property (@(posedge clk) disable iff (!rstN)
    csFallEv |=> driveEn);
  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(firstFlag) |-> $past(chA) == '0 && $past(bitPos) == '0);
endmodule

// File: rtl/serShiftData.sv
module serShiftData
  import serShiftPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NumCh*ResW-1:0] results,
  input  shiftStrobes_t         strobes,
  output logic [NumLanes-1:0]   laneBits
);
  localparam logic [BitW-1:0] MsbPos = BitW'(ResW - 1);

  logic [NumCh-1:0][ResW-1:0] snap;
  logic [BitW-1:0] bitSel;

  always_ff @(posedge clk) begin
    if (!rstN)                snap <= '0;
    else if (strobes.capture) snap <= results;
  end

  assign bitSel = MsbPos - strobes.bitPos;

  for (genvar l = 0; l < NumLanes; l++) begin : g_lane
    logic [ChW-1:0] chSel;
    assign chSel       = (l == 0) ? strobes.chA : strobes.chB;
    assign laneBits[l] = snap[chSel][bitSel];
  end

  // R8
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(snap));
endmodule

// File: rtl/dual_lane_shifter.sv
module dual_lane_shifter
  import serShiftPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  load,
  input  logic [NumCh*ResW-1:0] results,
  input  logic                  csN,
  input  logic                  sclk,
  output logic                  doutA,
  output logic                  doutB,
  output logic                  driveEn,
  output logic                  firstData
);
  shiftStrobes_t strobes;
  logic [NumLanes-1:0] laneBits;

  serShiftCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .load(load), .csN(csN), .sclk(sclk),
    .strobes(strobes), .driveEn(driveEn), .firstFlag(firstData)
  );

  serShiftData i_data (
    .clk(clk), .rstN(rstN), .results(results),
    .strobes(strobes), .laneBits(laneBits)
  );

  assign doutA = laneBits[0];
  assign doutB = laneBits[1];
endmodule

// File: tb/test_dual_lane_shifter.sv
module test_dual_lane_shifter;
  localparam int Ch = 8;
  localparam int W  = 18;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, load, csN, sclk;
  logic [Ch*W-1:0] results;
  logic doutA, doutB, driveEn, firstData;
  logic [W-1:0] pat [Ch];
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  dual_lane_shifter i_dual_lane_shifter (
    .clk(clk), .rstN(rstN), .load(load), .results(results), .csN(csN),
    .sclk(sclk), .doutA(doutA), .doutB(doutB), .driveEn(driveEn),
    .firstData(firstData)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadPat(input int p);
    for (int k = 0; k < Ch; k++) begin
      pat[k] = W'((p * 127397 + k * 46547 + 174137) % 262144);
      results[k*W +: W] = pat[k];
    end
    load = 1'b1; waitC(1); load = 1'b0; waitC(1);
  endtask

  task automatic csLow;  csN = 1'b0; waitC(4); endtask
  task automatic csHigh; csN = 1'b1; waitC(4); endtask
  task automatic pulse;  sclk = 1'b1; waitC(4); sclk = 1'b0; waitC(4); endtask

  // read one 18-clock channel at global position g
  task automatic readChan(input int g, input bit flagStart);
    int a = g % Ch;
    int b = (g + Ch/2) % Ch;
    chk($sformatf("R1 laneA msb g=%0d", g), doutA, pat[a][W-1]);
    chk($sformatf("R3 laneB msb g=%0d", g), doutB, pat[b][W-1]);
    chk($sformatf("R6 R7 flag start g=%0d", g), firstData, flagStart);
    for (int bi = W-2; bi >= 0; bi--) begin
      sclk = 1'b1; waitC(4);
      chk($sformatf("R2 laneA g=%0d bit=%0d", g, bi), doutA, pat[a][bi]);
      chk($sformatf("R3 laneB g=%0d bit=%0d", g, bi), doutB, pat[b][bi]);
      sclk = 1'b0; waitC(4);
    end
    chk($sformatf("R6 flag before 18th g=%0d", g), firstData, flagStart);
    pulse();
    chk($sformatf("R6 flag after 18th fall g=%0d", g), firstData, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; load = 1'b0; csN = 1'b1; sclk = 1'b0; results = '0;
    waitC(5); rstN = 1'b1; waitC(2);
    chk("R5 reset driveEn", driveEn, 1'b0);
    chk("R6 reset flag", firstData, 1'b0);

    // dual-lane read split over two frames
    loadPat(1);
    chk("R8 load msb", doutA, pat[0][W-1]);
    csLow();
    chk("R1 driveEn", driveEn, 1'b1);
    for (int g = 0; g < 4; g++) readChan(g, g == 0);
    csHigh();
    chk("R5 release driveEn", driveEn, 1'b0);
    chk("R5 release flag", firstData, 1'b0);
    csLow();
    // R4 R5 continuation; R7 channel 1 now on lane B
    for (int g = 4; g < 8; g++) readChan(g, 1'b0);
    csHigh();

    // framed per channel
    loadPat(2);
    for (int g = 0; g < Ch; g++) begin
      csLow();
      chk("R1 framed driveEn", driveEn, 1'b1);
      readChan(g, g == 0);
      csHigh();
      chk("R5 framed release", driveEn, 1'b0);
    end

    // single-lane 144-clock read under one select, then wrap
    loadPat(3);
    csLow();
    for (int g = 0; g < 2*Ch; g++) readChan(g, g == 0);
    csHigh();

    // load rewinds mid-channel; sclk ignored while deselected
    loadPat(4);
    csLow();
    for (int i = 0; i < 5; i++) pulse();
    chk("R2 mid bit", doutA, pat[0][W-6]);
    csHigh();
    loadPat(5);
    for (int i = 0; i < 5; i++) pulse();
    chk("R9 ignored laneA", doutA, pat[0][W-1]);
    chk("R9 ignored laneB", doutB, pat[Ch/2][W-1]);
    csLow();
    readChan(0, 1'b1);
    csHigh();
    for (int i = 0; i < 7; i++) pulse();
    chk("R9 held position", doutA, pat[1][W-1]);
    csLow();
    readChan(1, 1'b0);
    csHigh();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule